// File: doc/BRIEF.md
# Converter power-up and conversion-start sequencer

This block brings an analog-to-digital converter out of its powered-down state and launches conversions. When software sets the enable input, the block first switches on the analog supply and waits for the regulator to report that the supply is stable. It then powers up the converter core, and also the gain amplifier when a differential channel is latched. Power-up lasts a warm-up time counted in converter clock ticks. The length of that time is set by two timing fields.

Software may write the start bit at any time while the block is enabled. A request made before warm-up ends is held and fires on the cycle after the last warm-up tick. A request made when the converter is ready fires on the next cycle. The channel select is latched into the block while the select window is open, and the block reports whether that window is open. Clearing enable at any point aborts the sequence, powers everything down and drops any held request. The regulator and the converter are modelled as simple handshakes: `supplyOk` reports a stable supply and `convDone` marks the end of a conversion.

Top module: `adc_startup_seq`

## Requirements
- R1: While `enable` is sampled low, from the next cycle `supplyEn`, `adcPowerUp`, `ampPowerUp`, `convStart`, `startBusy` and `chanOpen` are 0 and `chanLatched`/`diffLatched` are 0. A start request held at that moment is discarded, and after re-enabling no `convStart` occurs without a new request.
- R2: On the cycle after `enable` is first sampled high, `supplyEn` is 1. `adcPowerUp` stays 0 until an edge at which `supplyOk` is sampled 1 in the supply-wait phase, and is 1 from the next cycle.
- R3: `ampPowerUp` is 1 exactly when `adcPowerUp` is 1 and the latched channel is differential (`diffLatched` = 1). For a single-ended channel it stays 0.
- R4: Warm-up lasts exactly (sutField+1)*4 + (thtField+1) clock cycles on which `convClkEn` is 1, counted from the first cycle with `adcPowerUp` = 1. The converter is ready, or the held conversion starts, on the cycle after the edge that samples the last such tick.
- R5: A start written during the supply-wait or warm-up phase sets `startBusy` from the next cycle. `convStart` then pulses on the cycle after the last warm-up tick, with no further write needed.
- R6: The channel is captured into `chanLatched`/`diffLatched` at the edge where `enable` is first sampled high. It is also captured at every edge while `chanOpen` is 1. `chanOpen` is 1 in the supply-wait phase until a start is written, and in the ready phase. While `chanOpen` is 0, the latch holds its value.
- R7: A start written in the ready phase gives a `convStart` pulse of exactly one cycle on the next cycle.
- R8: `startBusy` reads 1 from the cycle after the start write until the cycle after `convDone` is sampled during the conversion. It then reads 0 again.
- R9: Start writes made while a request is already held or a conversion is running have no effect: no extra `convStart` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable bit |
| startWr | input | 1 | One-cycle write of 1 to the start bit |
| chanSel | input | CH_W | Requested input channel |
| chanDiff | input | 1 | Requested channel is differential |
| sutField | input | SUT_W | Start-up time field |
| thtField | input | THT_W | Track-and-hold time field |
| supplyOk | input | 1 | Analog supply stable indication |
| convClkEn | input | 1 | Converter clock tick |
| convDone | input | 1 | Converter reports end of conversion |
| supplyEn | output | 1 | Analog supply enable |
| adcPowerUp | output | 1 | Converter core power-up |
| ampPowerUp | output | 1 | Gain amplifier power-up |
| convStart | output | 1 | One-cycle conversion start pulse |
| chanLatched | output | CH_W | Channel in effect |
| diffLatched | output | 1 | Latched channel is differential |
| chanOpen | output | 1 | Channel select may still change |
| startBusy | output | 1 | Start bit read-back |

## Verification
The hardest case to reach is the abort path: clearing enable while a request is held in the middle of warm-up. It must be shown that the held request is truly gone, and that shows only as a missing `convStart` after a full second warm-up. The stimulus gets there by raising the supply and writing start at a tick-divided rate, then dropping enable part way through the count. It then re-enables and waits well past the warm-up length while it counts pulses. A second hard spot is a start written on the very edge that raises enable while the supply is already stable. There the channel window must close before it ever shows as open, and the bench changes the select afterwards to prove that the latch holds.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SUPPLY = 3'd1,
    ST_WARM   = 3'd2,
    ST_READY  = 3'd3,
    ST_CONV   = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic latchChan;
    logic clearChan;
  } seq_ctl_t;

endpackage

// File: rtl/adcseq_dpath.sv
module adcseq_dpath
  import adcseq_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int SUT_W = 5,
  parameter int THT_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_ctl_t         ctl,
  input  logic [SUT_W-1:0] sutField,
  input  logic [THT_W-1:0] thtField,
  input  logic [CH_W-1:0]  chanSel,
  input  logic             chanDiff,
  output logic             cntLast,
  output logic [CH_W-1:0]  chanLatched,
  output logic             diffLatched
);

  logic [CNT_W-1:0] warmCnt;
  logic [CNT_W-1:0] warmTotal;
  logic [CNT_W-1:0] sutPart;
  logic [CNT_W-1:0] thtPart;

  // start-up part counts in groups of four ticks, track-and-hold part in single ticks
  always_comb begin
    sutPart   = (CNT_W'(sutField) + CNT_W'(1)) << 2;
    thtPart   = CNT_W'(thtField) + CNT_W'(1);
    warmTotal = sutPart + thtPart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (ctl.loadCnt) begin
      warmCnt <= warmTotal;
    end else if (ctl.decCnt && warmCnt != '0) begin
      warmCnt <= warmCnt - CNT_W'(1);
    end
  end

  assign cntLast = (warmCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanLatched <= '0;
      diffLatched <= 1'b0;
    end else if (ctl.clearChan) begin
      chanLatched <= '0;
      diffLatched <= 1'b0;
    end else if (ctl.latchChan) begin
      chanLatched <= chanSel;
      diffLatched <= chanDiff;
    end
  end

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     startWr,
  input  logic     supplyOk,
  input  logic     convClkEn,
  input  logic     convDone,
  input  logic     cntLast,
  output seq_ctl_t ctl,
  output logic     supplyEn,
  output logic     adcPowerUp,
  output logic     convStart,
  output logic     chanOpen,
  output logic     startBusy
);

  seq_state_t state;
  seq_state_t stateNext;
  logic       pend;
  logic       pendNext;
  logic       startNext;
  logic       warmEnd;

  assign warmEnd = convClkEn && cntLast;

  always_comb begin
    stateNext = state;
    pendNext  = pend;
    startNext = 1'b0;
    if (!enable) begin
      stateNext = ST_OFF;
      pendNext  = 1'b0;
    end else begin
      unique case (state)
        ST_OFF: begin
          stateNext = ST_SUPPLY;
          pendNext  = startWr;
        end
        ST_SUPPLY: begin
          if (startWr) pendNext = 1'b1;
          if (supplyOk) stateNext = ST_WARM;
        end
        ST_WARM: begin
          if (warmEnd) begin
            if (pend || startWr) begin
              stateNext = ST_CONV;
              startNext = 1'b1;
              pendNext  = 1'b0;
            end else begin
              stateNext = ST_READY;
            end
          end else if (startWr) begin
            pendNext = 1'b1;
          end
        end
        ST_READY: begin
          if (startWr) begin
            stateNext = ST_CONV;
            startNext = 1'b1;
          end
        end
        ST_CONV: begin
          if (convDone) stateNext = ST_READY;
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      pend      <= 1'b0;
      convStart <= 1'b0;
    end else begin
      state     <= stateNext;
      pend      <= pendNext;
      convStart <= startNext;
    end
  end

  always_comb begin
    supplyEn   = (state != ST_OFF);
    adcPowerUp = (state == ST_WARM) || (state == ST_READY) || (state == ST_CONV);
    chanOpen   = ((state == ST_SUPPLY) && !pend) || (state == ST_READY);
    startBusy  = pend || (state == ST_CONV);
  end

  always_comb begin
    ctl.clearChan = !enable;
    ctl.latchChan = enable && (chanOpen || (state == ST_OFF));
    ctl.loadCnt   = enable && (state == ST_SUPPLY) && supplyOk;
    ctl.decCnt    = enable && (state == ST_WARM) && convClkEn;
  end

endmodule

// File: rtl/adc_startup_seq.sv
module adc_startup_seq
  import adcseq_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int SUT_W = 5,
  parameter int THT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             startWr,
  input  logic [CH_W-1:0]  chanSel,
  input  logic             chanDiff,
  input  logic [SUT_W-1:0] sutField,
  input  logic [THT_W-1:0] thtField,
  input  logic             supplyOk,
  input  logic             convClkEn,
  input  logic             convDone,
  output logic             supplyEn,
  output logic             adcPowerUp,
  output logic             ampPowerUp,
  output logic             convStart,
  output logic [CH_W-1:0]  chanLatched,
  output logic             diffLatched,
  output logic             chanOpen,
  output logic             startBusy
);

  localparam int SUT_BITS = SUT_W + 2;
  localparam int CNT_W    = ((SUT_BITS > THT_W) ? SUT_BITS : THT_W) + 1;

  seq_ctl_t ctl;
  logic     cntLast;

  adcseq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .startWr   (startWr),
    .supplyOk  (supplyOk),
    .convClkEn (convClkEn),
    .convDone  (convDone),
    .cntLast   (cntLast),
    .ctl       (ctl),
    .supplyEn  (supplyEn),
    .adcPowerUp(adcPowerUp),
    .convStart (convStart),
    .chanOpen  (chanOpen),
    .startBusy (startBusy)
  );

  adcseq_dpath #(
    .CH_W (CH_W),
    .SUT_W(SUT_W),
    .THT_W(THT_W),
    .CNT_W(CNT_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sutField   (sutField),
    .thtField   (thtField),
    .chanSel    (chanSel),
    .chanDiff   (chanDiff),
    .cntLast    (cntLast),
    .chanLatched(chanLatched),
    .diffLatched(diffLatched)
  );

  assign ampPowerUp = adcPowerUp && diffLatched;

endmodule

// File: rtl/adc_startup_seq_chk.sv
module adc_startup_seq_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            supplyOk,
  input logic            convDone,
  input logic            supplyEn,
  input logic            adcPowerUp,
  input logic            ampPowerUp,
  input logic            convStart,
  input logic [CH_W-1:0] chanLatched,
  input logic            diffLatched,
  input logic            chanOpen,
  input logic            startBusy
);

  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!supplyEn && !adcPowerUp && !startBusy && !convStart && !chanOpen));

  a_r2_power_after_supply: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcPowerUp) |-> $past(supplyOk));

  a_r3_amp_only_diff: assert property (@(posedge clk) disable iff (!rstN)
    ampPowerUp |-> (adcPowerUp && diffLatched));

  a_r6_latch_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (enable && supplyEn && !chanOpen) |=> $stable(chanLatched));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  a_r8_busy_during_start: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> startBusy);

  a_r8_busy_clears_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBusy) |-> ($past(convDone) || !$past(enable)));

endmodule

bind adc_startup_seq adc_startup_seq_chk #(.CH_W(CH_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .supplyOk   (supplyOk),
  .convDone   (convDone),
  .supplyEn   (supplyEn),
  .adcPowerUp (adcPowerUp),
  .ampPowerUp (ampPowerUp),
  .convStart  (convStart),
  .chanLatched(chanLatched),
  .diffLatched(diffLatched),
  .chanOpen   (chanOpen),
  .startBusy  (startBusy)
);

// File: tb/adc_startup_seq_tb_top.sv
module adc_startup_seq_tb_top;

  localparam int CH_W  = 5;
  localparam int SUT_W = 5;
  localparam int THT_W = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             startWr = 1'b0;
  logic [CH_W-1:0]  chanSel = '0;
  logic             chanDiff = 1'b0;
  logic [SUT_W-1:0] sutField = '0;
  logic [THT_W-1:0] thtField = '0;
  logic             supplyOk = 1'b0;
  logic             convClkEn = 1'b0;
  logic             convDone = 1'b0;
  logic             supplyEn, adcPowerUp, ampPowerUp, convStart;
  logic [CH_W-1:0]  chanLatched;
  logic             diffLatched, chanOpen, startBusy;

  adc_startup_seq #(.CH_W(CH_W), .SUT_W(SUT_W), .THT_W(THT_W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .startWr(startWr),
    .chanSel(chanSel), .chanDiff(chanDiff), .sutField(sutField),
    .thtField(thtField), .supplyOk(supplyOk), .convClkEn(convClkEn),
    .convDone(convDone), .supplyEn(supplyEn), .adcPowerUp(adcPowerUp),
    .ampPowerUp(ampPowerUp), .convStart(convStart), .chanLatched(chanLatched),
    .diffLatched(diffLatched), .chanOpen(chanOpen), .startBusy(startBusy)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tickDiv = 1;
  int tickPh = 0;
  bit measuring = 0;
  bit prevPow = 0;
  int warmTicks = 0;
  int pulses = 0;

  // behavioural reference: phase 0 off, 1 supply wait, 2 warm-up, 3 ready, 4 converting
  int mPhase = 0;
  int mLeft = 0;
  bit mHeld = 0;
  bit mStart = 0;
  int mCh = 0;
  bit mDiff = 0;

  always @(posedge clk) begin
    bit canLatch;
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mHeld = 0; mStart = 0; mCh = 0; mDiff = 0;
    end else begin
      mStart = 0;
      if (!enable) begin
        mPhase = 0; mHeld = 0; mCh = 0; mDiff = 0;
      end else begin
        canLatch = (mPhase == 0) || (mPhase == 1 && !mHeld) || (mPhase == 3);
        if (canLatch) begin mCh = int'(chanSel); mDiff = chanDiff; end
        case (mPhase)
          0: begin mPhase = 1; mHeld = startWr; end
          1: begin
            if (startWr) mHeld = 1;
            if (supplyOk) begin
              mPhase = 2;
              mLeft = (int'(sutField) + 1) * 4 + int'(thtField) + 1;
            end
          end
          2: begin
            if (convClkEn && mLeft == 1) begin
              if (mHeld || startWr) begin mPhase = 4; mStart = 1; mHeld = 0; end
              else mPhase = 3;
            end else begin
              if (startWr) mHeld = 1;
              if (convClkEn) mLeft = mLeft - 1;
            end
          end
          3: if (startWr) begin mPhase = 4; mStart = 1; end
          4: if (convDone) mPhase = 3;
          default: mPhase = 0;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    bit eOpen;
    eOpen = (mPhase == 1 && !mHeld) || (mPhase == 3);
    chk(supplyEn == (mPhase != 0), "R2 supplyEn", int'(supplyEn), int'(mPhase != 0));
    chk(adcPowerUp == (mPhase >= 2), "R2 adcPowerUp", int'(adcPowerUp), int'(mPhase >= 2));
    chk(ampPowerUp == ((mPhase >= 2) && mDiff), "R3 ampPowerUp", int'(ampPowerUp),
        int'((mPhase >= 2) && mDiff));
    chk(convStart == mStart, "R7 convStart", int'(convStart), int'(mStart));
    chk(int'(chanLatched) == mCh, "R6 chanLatched", int'(chanLatched), mCh);
    chk(diffLatched == mDiff, "R6 diffLatched", int'(diffLatched), int'(mDiff));
    chk(chanOpen == eOpen, "R6 chanOpen", int'(chanOpen), int'(eOpen));
    chk(startBusy == (mHeld || mPhase == 4), "R8 startBusy", int'(startBusy),
        int'(mHeld || mPhase == 4));
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rstN) compareAll();
    if (convStart) pulses++;
    if (adcPowerUp && !prevPow) measuring = 1;
    if (measuring && (chanOpen || convStart || !adcPowerUp)) measuring = 0;
    prevPow = adcPowerUp;
    tickPh++;
    convClkEn = (tickPh % tickDiv) == 0;
    if (measuring && convClkEn) warmTicks++;
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulseStart();
    startWr = 1'b1;
    step();
    startWr = 1'b0;
  endtask

  initial begin
    stepN(3);
    rstN = 1'b1;
    step();
    // R1: reset state
    chk(!supplyEn && !adcPowerUp && !convStart && !startBusy && chanLatched == 0,
        "R1 reset state", int'(supplyEn), 0);

    // single-ended, slow supply, minimum warm-up, tick every cycle
    tickDiv = 1; sutField = 0; thtField = 0;
    chanSel = 5'd3; chanDiff = 1'b0; enable = 1'b1;
    step();
    step();
    chk(supplyEn && !adcPowerUp, "R2 supply before power", int'(adcPowerUp), 0);
    chanSel = 5'd9;
    stepN(3);
    chk(chanOpen && chanLatched == 5'd9, "R6 select tracks while open", int'(chanLatched), 9);
    supplyOk = 1'b1;
    warmTicks = 0;
    stepN(12);
    chk(warmTicks == 5, "R4 minimum warm-up ticks", warmTicks, 5);
    chk(!ampPowerUp && adcPowerUp, "R3 single-ended amp off", int'(ampPowerUp), 0);
    pulses = 0;
    pulseStart();
    chk(convStart && startBusy, "R7 start from ready", int'(convStart), 1);
    step();
    chk(!convStart, "R7 pulse width one", int'(convStart), 0);
    stepN(3);
    convDone = 1'b1; step(); convDone = 1'b0;
    step();
    chk(!startBusy, "R8 busy clears after done", int'(startBusy), 0);
    chk(pulses == 1, "R7 pulse count", pulses, 1);

    // differential, longer warm-up, divided ticks, start held during warm-up
    enable = 1'b0; supplyOk = 1'b0;
    step();
    step();
    chk(!supplyEn && chanLatched == 0, "R1 disable clears", int'(supplyEn), 0);
    tickDiv = 3; sutField = 5'd3; thtField = 2'd2;
    chanSel = 5'd17; chanDiff = 1'b1; enable = 1'b1;
    stepN(2);
    supplyOk = 1'b1;
    warmTicks = 0;
    pulses = 0;
    stepN(4);
    chk(ampPowerUp, "R3 differential amp on", int'(ampPowerUp), 1);
    pulseStart();
    chk(startBusy && !chanOpen, "R5 start held in warm-up", int'(startBusy), 1);
    pulseStart();
    stepN(80);
    chk(warmTicks == 19, "R4 warm-up ticks sut3 tht2", warmTicks, 19);
    chk(pulses == 1, "R5 held start fires once", pulses, 1);
    pulseStart();
    pulseStart();
    stepN(2);
    chk(pulses == 1, "R9 writes while converting ignored", pulses, 1);
    convDone = 1'b1; step(); convDone = 1'b0;
    step();
    chk(!startBusy && chanOpen, "R8 back to ready", int'(startBusy), 0);

    // supply already stable, start together with enable: window closed at once
    enable = 1'b0; supplyOk = 1'b0;
    stepN(2);
    tickDiv = 2; sutField = 5'd1; thtField = 2'd1;
    supplyOk = 1'b1; chanSel = 5'd7; chanDiff = 1'b0; pulses = 0;
    enable = 1'b1; startWr = 1'b1;
    step();
    startWr = 1'b0;
    chanSel = 5'd12;
    step();
    chk(!chanOpen && chanLatched == 5'd7, "R6 window closed by start", int'(chanLatched), 7);
    stepN(40);
    chk(chanLatched == 5'd7, "R6 latch frozen through conversion", int'(chanLatched), 7);
    chk(pulses == 1, "R5 start with enable fires", pulses, 1);

    // abort with a held request during warm-up
    convDone = 1'b1; step(); convDone = 1'b0;
    enable = 1'b0; supplyOk = 1'b0;
    stepN(2);
    tickDiv = 3; sutField = 5'd4; thtField = 2'd3;
    enable = 1'b1;
    stepN(2);
    supplyOk = 1'b1;
    stepN(3);
    pulseStart();
    stepN(5);
    enable = 1'b0; supplyOk = 1'b0;
    step();
    step();
    chk(!startBusy && !adcPowerUp && !supplyEn, "R1 abort drops request", int'(startBusy), 0);
    pulses = 0;
    enable = 1'b1;
    stepN(2);
    supplyOk = 1'b1;
    stepN(120);
    chk(pulses == 0, "R1 no start after abort", pulses, 0);
    chk(chanOpen && adcPowerUp, "R4 ready after abort warm-up", int'(chanOpen), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule